// File: doc/BRIEF.md
# Three-Level DMA Address Sequencer

This block steps through one transfer descriptor and emits a source and destination address pair for every byte moved. The transfer has three nested levels. Bytes make up an array. Arrays make up a frame. Frames make up a block. The datapath that moves the data reads one address pair per beat and uses the side-band pulses to know where a trigger's work ends and when the whole descriptor is finished.

Software sets up the active descriptor directly. It can also fill a 256-entry descriptor table that shares the same data port. Each trigger pulse moves one array, one frame or the whole block, depending on the descriptor's sync field. Each side has its own array stride and frame stride, and each side can be frozen at a constant address to feed a FIFO. When the last beat of the block goes out, the descriptor can reload itself from the table entry its link field names. This supports ping-pong and circular chains with no processor action. The link value 255 ends the chain.

Top module: `dma3d_sequencer`

## Requirements
- R1: The first beat (`beatValid` high) appears in the cycle after the clock edge that samples `trig`. Beats run bytes within an array, then arrays within a frame, then frames within a block. A descriptor yields arrayBytes × frameArrays × blockFrames beats in total, and the first beat carries the start addresses.
- R2: On a side in increment mode, the address rises by 1 from one byte to the next within an array.
- R3: The first byte of the next array sits at the current array's first address plus that side's array index. The index is a 16-bit two's-complement value, sign-extended, and each side uses its own.
- R4: The first byte of the next frame sits at the current frame's first address plus that side's frame index. This is also two's-complement and separate per side.
- R5: A side with its constant bit set outputs its start address on every beat of the descriptor.
- R6: The sync field sets how much one trigger moves: 0 moves one array, 1 moves one frame, and 2 or 3 moves the whole block. `trigDone` is high on the last beat a trigger produces, and beats stop after it.
- R7: `descDone` is high only on the final beat of the block.
- R8: If the link field is not 255, `linkReq` is high together with `descDone`. The active descriptor is then replaced by the table entry the link field names, and the next triggers run that entry.
- R9: If the link field is 255, there is no `linkReq` and all counts become zero. A later trigger then gives a one-cycle `trigErr` pulse, one cycle after it is sampled, and produces no beat.
- R10: While beats are running, `trig` and `descLoad` are ignored.
- R11: A descriptor loaded with any count equal to zero is exhausted. A trigger on it gives `trigErr` and no beats.
- R12: After reset there are no beats, and the sequencer is exhausted until a descriptor is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblWe | input | 1 | Write `descIn` into the table entry selected by `tblAddr` |
| tblAddr | input | 8 | Table entry to write |
| descLoad | input | 1 | Load `descIn` as the active descriptor when idle |
| descIn | input | 188 | Packed descriptor (see `desc_t` in the package) |
| trig | input | 1 | Trigger pulse |
| beatValid | output | 1 | An address pair is presented this cycle |
| srcAddr | output | 32 | Source address of the current beat |
| dstAddr | output | 32 | Destination address of the current beat |
| trigDone | output | 1 | Last beat of the current trigger |
| descDone | output | 1 | Last beat of the descriptor |
| linkReq | output | 1 | Descriptor reloads from its link entry at this beat |
| trigErr | output | 1 | Trigger arrived with no remaining counts |

## Verification
The hardest state to reach is the one right after a link reload. The new descriptor's counts, strides and sync mode must take over in the same edge that retires the old block. This only happens after a complete multi-trigger walk, and errors there show up only in the next trigger's addresses. The stimulus reaches it with directed ping-pong chains that bounce twice between two table entries. It also uses random pairs, where a random descriptor is linked to a random table entry and both are walked under their own sync modes. Triggers and loads sent in the middle of a running block show that neither disturbs the beat count or the active descriptor.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int IDX_W  = 16;
  localparam int PTR_W  = 8;
  localparam logic [PTR_W-1:0] LINK_NONE = '1;

  typedef enum logic [1:0] {
    SYNC_ARRAY = 2'd0,
    SYNC_FRAME = 2'd1,
    SYNC_BLOCK = 2'd2,
    SYNC_ALL   = 2'd3
  } sync_e;

  typedef struct packed {
    logic [ADDR_W-1:0] srcStart;
    logic [ADDR_W-1:0] dstStart;
    logic [CNT_W-1:0]  arrayBytes;
    logic [CNT_W-1:0]  frameArrays;
    logic [CNT_W-1:0]  blockFrames;
    logic [IDX_W-1:0]  srcArrIdx;
    logic [IDX_W-1:0]  dstArrIdx;
    logic [IDX_W-1:0]  srcFrmIdx;
    logic [IDX_W-1:0]  dstFrmIdx;
    logic              srcConst;
    logic              dstConst;
    sync_e             syncMode;
    logic [PTR_W-1:0]  linkPtr;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef struct packed {
    logic loadExt;
    logic linkLoad;
    logic clear;
    logic stepByte;
    logic stepArray;
    logic stepFrame;
  } strobe_t;

  function automatic logic [ADDR_W-1:0] sextIdx(input logic [IDX_W-1:0] v);
    return {{(ADDR_W-IDX_W){v[IDX_W-1]}}, v};
  endfunction
endpackage

// File: rtl/dma3d_addr_side.sv
module dma3d_addr_side
  import dma3d_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              isLoad,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              stepByte,
  input  logic              stepArray,
  input  logic              stepFrame,
  input  logic              isConst,
  input  logic [IDX_W-1:0]  arrIdx,
  input  logic [IDX_W-1:0]  frmIdx,
  output logic [ADDR_W-1:0] curAddr
);
  logic [ADDR_W-1:0] arrBase, frmBase, nextArr, nextFrm;

  assign nextArr = arrBase + sextIdx(arrIdx);
  assign nextFrm = frmBase + sextIdx(frmIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      arrBase <= '0;
      frmBase <= '0;
    end else if (isLoad) begin
      curAddr <= loadAddr;
      arrBase <= loadAddr;
      frmBase <= loadAddr;
    end else if (!isConst) begin
      if (stepByte) begin
        curAddr <= curAddr + ADDR_W'(1);
      end else if (stepArray) begin
        curAddr <= nextArr;
        arrBase <= nextArr;
      end else if (stepFrame) begin
        curAddr <= nextFrm;
        arrBase <= nextFrm;
        frmBase <= nextFrm;
      end
    end
  end
endmodule

// File: rtl/dma3d_datapath.sv
module dma3d_datapath
  import dma3d_pkg::*;
#(
  parameter int TBL_DEPTH = 1 << PTR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              tblWe,
  input  logic [PTR_W-1:0]  tblAddr,
  input  desc_t             descIn,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic              lastByte,
  output logic              lastArr,
  output logic              lastFrm,
  output logic              exhausted,
  output logic              hasLink,
  output sync_e             syncMode
);
  localparam int SIDES = 2;

  desc_t descTbl [TBL_DEPTH];
  desc_t nextDesc;
  logic  loadAny, anyZero;

  logic [CNT_W-1:0] cfgBytes, cfgArrays;
  logic [IDX_W-1:0] cfgArrIdx [SIDES];
  logic [IDX_W-1:0] cfgFrmIdx [SIDES];
  logic             cfgConst  [SIDES];
  logic [PTR_W-1:0] cfgLink;
  sync_e            cfgSync;

  logic [CNT_W-1:0] byteLeft, arrLeft, frmLeft;
  logic [ADDR_W-1:0] sideAddr [SIDES];

  always_ff @(posedge clk) begin
    if (tblWe) descTbl[tblAddr] <= descIn;
  end

  assign nextDesc = stb.linkLoad ? descTbl[cfgLink] : descIn;
  assign loadAny  = stb.loadExt | stb.linkLoad;
  assign anyZero  = (nextDesc.arrayBytes == '0) | (nextDesc.frameArrays == '0) |
                    (nextDesc.blockFrames == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBytes     <= '0;
      cfgArrays    <= '0;
      cfgArrIdx[0] <= '0;
      cfgArrIdx[1] <= '0;
      cfgFrmIdx[0] <= '0;
      cfgFrmIdx[1] <= '0;
      cfgConst[0]  <= 1'b0;
      cfgConst[1]  <= 1'b0;
      cfgLink      <= LINK_NONE;
      cfgSync      <= SYNC_ARRAY;
    end else if (loadAny) begin
      cfgBytes     <= nextDesc.arrayBytes;
      cfgArrays    <= nextDesc.frameArrays;
      cfgArrIdx[0] <= nextDesc.srcArrIdx;
      cfgArrIdx[1] <= nextDesc.dstArrIdx;
      cfgFrmIdx[0] <= nextDesc.srcFrmIdx;
      cfgFrmIdx[1] <= nextDesc.dstFrmIdx;
      cfgConst[0]  <= nextDesc.srcConst;
      cfgConst[1]  <= nextDesc.dstConst;
      cfgLink      <= nextDesc.linkPtr;
      cfgSync      <= nextDesc.syncMode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteLeft <= '0;
      arrLeft  <= '0;
      frmLeft  <= '0;
    end else if (loadAny) begin
      byteLeft <= anyZero ? '0 : nextDesc.arrayBytes;
      arrLeft  <= anyZero ? '0 : nextDesc.frameArrays;
      frmLeft  <= anyZero ? '0 : nextDesc.blockFrames;
    end else if (stb.clear) begin
      byteLeft <= '0;
      arrLeft  <= '0;
      frmLeft  <= '0;
    end else if (stb.stepByte) begin
      byteLeft <= byteLeft - CNT_W'(1);
    end else if (stb.stepArray) begin
      byteLeft <= cfgBytes;
      arrLeft  <= arrLeft - CNT_W'(1);
    end else if (stb.stepFrame) begin
      byteLeft <= cfgBytes;
      arrLeft  <= cfgArrays;
      frmLeft  <= frmLeft - CNT_W'(1);
    end
  end

  for (genvar gi = 0; gi < SIDES; gi++) begin : g_side
    dma3d_addr_side u_side (
      .clk       (clk),
      .rstN      (rstN),
      .isLoad    (loadAny),
      .loadAddr  ((gi == 0) ? nextDesc.srcStart : nextDesc.dstStart),
      .stepByte  (stb.stepByte),
      .stepArray (stb.stepArray),
      .stepFrame (stb.stepFrame),
      .isConst   (cfgConst[gi]),
      .arrIdx    (cfgArrIdx[gi]),
      .frmIdx    (cfgFrmIdx[gi]),
      .curAddr   (sideAddr[gi])
    );
  end

  assign srcAddr   = sideAddr[0];
  assign dstAddr   = sideAddr[1];
  assign lastByte  = (byteLeft == CNT_W'(1));
  assign lastArr   = (arrLeft == CNT_W'(1));
  assign lastFrm   = (frmLeft == CNT_W'(1));
  assign exhausted = (frmLeft == '0);
  assign hasLink   = (cfgLink != LINK_NONE);
  assign syncMode  = cfgSync;
endmodule

// File: rtl/dma3d_ctrl.sv
module dma3d_ctrl
  import dma3d_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    trig,
  input  logic    descLoad,
  input  logic    lastByte,
  input  logic    lastArr,
  input  logic    lastFrm,
  input  logic    exhausted,
  input  logic    hasLink,
  input  sync_e   syncMode,
  output strobe_t stb,
  output logic    beatValid,
  output logic    trigDone,
  output logic    descDone,
  output logic    linkReq,
  output logic    trigErr
);
  logic busy, errQ, blockEnd, segEnd, perArray, perFrame;

  assign perArray = (syncMode == SYNC_ARRAY);
  assign perFrame = (syncMode == SYNC_FRAME);
  assign blockEnd = busy & lastByte & lastArr & lastFrm;
  assign segEnd   = busy & lastByte & (perArray | (lastArr & (perFrame | lastFrm)));

  always_comb begin
    stb           = '0;
    stb.loadExt   = descLoad & ~busy;
    stb.stepByte  = busy & ~lastByte;
    stb.stepArray = busy & lastByte & ~lastArr;
    stb.stepFrame = busy & lastByte & lastArr & ~lastFrm;
    stb.linkLoad  = blockEnd & hasLink;
    stb.clear     = blockEnd & ~hasLink;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      errQ <= 1'b0;
    end else begin
      errQ <= ~busy & trig & exhausted & ~descLoad;
      if (busy) begin
        if (segEnd) busy <= 1'b0;
      end else if (trig & ~exhausted & ~descLoad) begin
        busy <= 1'b1;
      end
    end
  end

  assign beatValid = busy;
  assign trigDone  = segEnd;
  assign descDone  = blockEnd;
  assign linkReq   = blockEnd & hasLink;
  assign trigErr   = errQ;
endmodule

// File: rtl/dma3d_sequencer.sv
module dma3d_sequencer
  import dma3d_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tblWe,
  input  logic [PTR_W-1:0]  tblAddr,
  input  logic              descLoad,
  input  logic [DESC_W-1:0] descIn,
  input  logic              trig,
  output logic              beatValid,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic              trigDone,
  output logic              descDone,
  output logic              linkReq,
  output logic              trigErr
);
  desc_t   descS;
  strobe_t stb;
  logic    lastByte, lastArr, lastFrm, exhausted, hasLink;
  sync_e   syncMode;

  assign descS = desc_t'(descIn);

  dma3d_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trig      (trig),
    .descLoad  (descLoad),
    .lastByte  (lastByte),
    .lastArr   (lastArr),
    .lastFrm   (lastFrm),
    .exhausted (exhausted),
    .hasLink   (hasLink),
    .syncMode  (syncMode),
    .stb       (stb),
    .beatValid (beatValid),
    .trigDone  (trigDone),
    .descDone  (descDone),
    .linkReq   (linkReq),
    .trigErr   (trigErr)
  );

  dma3d_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .tblWe     (tblWe),
    .tblAddr   (tblAddr),
    .descIn    (descS),
    .srcAddr   (srcAddr),
    .dstAddr   (dstAddr),
    .lastByte  (lastByte),
    .lastArr   (lastArr),
    .lastFrm   (lastFrm),
    .exhausted (exhausted),
    .hasLink   (hasLink),
    .syncMode  (syncMode)
  );
endmodule

// File: rtl/dma3d_checker.sv
module dma3d_checker (
  input logic clk,
  input logic rstN,
  input logic trig,
  input logic beatValid,
  input logic trigDone,
  input logic descDone,
  input logic linkReq,
  input logic trigErr
);
  assert_beats_follow_trigger_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(beatValid) |-> $past(trig));

  assert_done_inside_beat_R6: assert property (@(posedge clk) disable iff (!rstN)
    trigDone |-> beatValid);

  assert_block_end_closes_trigger_R7: assert property (@(posedge clk) disable iff (!rstN)
    descDone |-> trigDone);

  assert_link_only_at_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    linkReq |-> descDone);

  assert_error_without_beat_R9: assert property (@(posedge clk) disable iff (!rstN)
    trigErr |-> !beatValid);

  assert_error_single_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    trigErr |=> !trigErr);
endmodule

bind dma3d_sequencer dma3d_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .trig      (trig),
  .beatValid (beatValid),
  .trigDone  (trigDone),
  .descDone  (descDone),
  .linkReq   (linkReq),
  .trigErr   (trigErr)
);

// File: tb/test_dma3d_sequencer.sv
module test_dma3d_sequencer;
  import dma3d_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tblWe = 1'b0;
  logic descLoad = 1'b0;
  logic trig = 1'b0;
  logic [PTR_W-1:0] tblAddr = '0;
  desc_t descIn = '0;
  logic beatValid, trigDone, descDone, linkReq, trigErr;
  logic [ADDR_W-1:0] srcAddr, dstAddr;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma3d_sequencer i_dma3d_sequencer (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblAddr(tblAddr),
    .descLoad(descLoad), .descIn(descIn), .trig(trig),
    .beatValid(beatValid), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .trigDone(trigDone), .descDone(descDone), .linkReq(linkReq), .trigErr(trigErr)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] expAddr(input desc_t d, input bit side, input int k);
    int a = int'(d.arrayBytes);
    int b = int'(d.frameArrays);
    int byteI = k % a;
    int arrI = (k / a) % b;
    int frmI = k / (a * b);
    logic signed [IDX_W-1:0] ai, fi;
    logic [ADDR_W-1:0] start;
    start = side ? d.dstStart : d.srcStart;
    ai = side ? d.dstArrIdx : d.srcArrIdx;
    fi = side ? d.dstFrmIdx : d.srcFrmIdx;
    if (side ? d.dstConst : d.srcConst) return start;
    return start + ADDR_W'(frmI) * ADDR_W'(fi) + ADDR_W'(arrI) * ADDR_W'(ai) + ADDR_W'(byteI);
  endfunction

  task automatic pulseTrig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic loadDesc(input desc_t d);
    descIn = d;
    descLoad = 1'b1;
    @(negedge clk);
    descLoad = 1'b0;
  endtask

  task automatic writeEntry(input logic [PTR_W-1:0] idx, input desc_t d);
    descIn = d;
    tblAddr = idx;
    tblWe = 1'b1;
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  task automatic expectErr(input string req);
    pulseTrig();
    checkEq(req, "trigErr after empty trigger", trigErr, 1);
    checkEq(req, "no beat on empty trigger", beatValid, 0);
    @(negedge clk);
    checkEq(req, "trigErr single cycle", trigErr, 0);
    checkEq(req, "still no beat", beatValid, 0);
  endtask

  // Walks a whole descriptor: R1..R8 checked beat by beat.
  task automatic runDesc(input desc_t d);
    int a = int'(d.arrayBytes);
    int b = int'(d.frameArrays);
    int c = int'(d.blockFrames);
    int total = a * b * c;
    int seg = (d.syncMode == SYNC_ARRAY) ? a : (d.syncMode == SYNC_FRAME) ? a * b : total;
    int k = 0;
    for (int t = 0; t < total / seg; t++) begin
      pulseTrig();
      for (int n = 0; n < seg; n++) begin
        checkEq("R1", "beatValid during walk", beatValid, 1);
        checkEq("R2_R3_R4_R5", "srcAddr", srcAddr, expAddr(d, 1'b0, k));
        checkEq("R2_R3_R4_R5", "dstAddr", dstAddr, expAddr(d, 1'b1, k));
        checkEq("R6", "trigDone", trigDone, (n == seg - 1));
        checkEq("R7", "descDone", descDone, (k == total - 1));
        checkEq("R8", "linkReq", linkReq, (k == total - 1) && (d.linkPtr != LINK_NONE));
        k++;
        @(negedge clk);
      end
      checkEq("R6", "beats stop after segment", beatValid, 0);
    end
  endtask

  function automatic desc_t randDesc();
    desc_t d = '0;
    d.srcStart    = $urandom;
    d.dstStart    = $urandom;
    d.arrayBytes  = CNT_W'($urandom_range(4, 1));
    d.frameArrays = CNT_W'($urandom_range(3, 1));
    d.blockFrames = CNT_W'($urandom_range(3, 1));
    d.srcArrIdx   = IDX_W'($urandom_range(64, 0)) - IDX_W'(32);
    d.dstArrIdx   = IDX_W'($urandom_range(64, 0)) - IDX_W'(32);
    d.srcFrmIdx   = IDX_W'($urandom_range(512, 0)) - IDX_W'(256);
    d.dstFrmIdx   = IDX_W'($urandom_range(512, 0)) - IDX_W'(256);
    d.srcConst    = ($urandom_range(3, 0) == 0);
    d.dstConst    = ($urandom_range(3, 0) == 0);
    d.syncMode    = sync_e'($urandom_range(3, 0));
    d.linkPtr     = LINK_NONE;
    return d;
  endfunction

  initial begin
    desc_t d, p1, p2, e, other;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12: reset state
    checkEq("R12", "beatValid after reset", beatValid, 0);
    checkEq("R12", "trigErr after reset", trigErr, 0);
    expectErr("R12");

    // R2 R3 R4: increment, whole block per trigger, mixed-sign strides
    d = '0;
    d.srcStart = 32'h1000; d.dstStart = 32'h8000;
    d.arrayBytes = 3; d.frameArrays = 2; d.blockFrames = 2;
    d.srcArrIdx = 16'd16; d.dstArrIdx = 16'hFFF8;
    d.srcFrmIdx = 16'd100; d.dstFrmIdx = 16'hFF00;
    d.syncMode = SYNC_BLOCK; d.linkPtr = LINK_NONE;
    loadDesc(d);
    runDesc(d);
    expectErr("R9");

    // R5 R6: constant source, frame per trigger
    d.srcConst = 1'b1; d.syncMode = SYNC_FRAME;
    loadDesc(d);
    runDesc(d);
    expectErr("R9");

    // R6: array per trigger, constant destination, sync value 3
    d.srcConst = 1'b0; d.dstConst = 1'b1; d.syncMode = SYNC_ARRAY;
    loadDesc(d);
    runDesc(d);
    d.dstConst = 1'b0; d.syncMode = SYNC_ALL;
    loadDesc(d);
    runDesc(d);

    // R8: ping-pong chain between entries 1 and 2
    p1 = d; p1.srcStart = 32'h2000; p1.syncMode = SYNC_FRAME; p1.linkPtr = 8'd2;
    p2 = d; p2.srcStart = 32'h3000; p2.arrayBytes = 2; p2.syncMode = SYNC_ARRAY; p2.linkPtr = 8'd1;
    writeEntry(8'd1, p1);
    writeEntry(8'd2, p2);
    loadDesc(p1);
    runDesc(p1);
    runDesc(p2);
    runDesc(p1);
    runDesc(p2);

    // R11: zero count descriptor
    d.frameArrays = 0; d.linkPtr = LINK_NONE;
    loadDesc(d);
    expectErr("R11");

    // R10: trigger and load during a running block are ignored
    d = '0;
    d.srcStart = 32'h4000; d.dstStart = 32'h5000;
    d.arrayBytes = 2; d.frameArrays = 2; d.blockFrames = 1;
    d.srcArrIdx = 16'd8; d.dstArrIdx = 16'd8;
    d.syncMode = SYNC_BLOCK; d.linkPtr = LINK_NONE;
    other = d; other.srcStart = 32'h9000;
    loadDesc(d);
    pulseTrig();
    n = 0;
    while (beatValid && n < 20) begin
      checkEq("R10", "srcAddr with stray inputs", srcAddr, expAddr(d, 1'b0, n));
      if (n == 1) begin
        descIn = other; trig = 1'b1; descLoad = 1'b1;
      end else begin
        trig = 1'b0; descLoad = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    trig = 1'b0; descLoad = 1'b0;
    checkEq("R10", "beat count unchanged", n, 4);
    expectErr("R10");

    // Random descriptors, half of them linked to a random table entry
    for (int it = 0; it < 40; it++) begin
      d = randDesc();
      if ($urandom_range(1, 0) == 1) begin
        e = randDesc();
        d.linkPtr = PTR_W'($urandom_range(254, 0));
        writeEntry(d.linkPtr, e);
        loadDesc(d);
        runDesc(d);
        runDesc(e);
      end else begin
        loadDesc(d);
        runDesc(d);
      end
      expectErr("R9");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule